// File: doc/BRIEF.md
# Soft Interrupt Priority Resolver

The resolver looks at a 17-bit vector of pending software interrupt requests and the processor's current 4-bit interrupt level. It reports whether any request may be taken and, if so, which level to service. Bits 1 to 15 each ask for the level equal to their own index. Bits 0 and 16 are timer-match flags, and each of them asks for level 14. A request is taken only when its level is strictly above the current level. The resolver returns the highest such level. When ordinary bit 15 and a level-14 timer flag are both eligible, bit 15 wins.

The block does not set or clear the vector, and it does not enter traps or compute vectors. It is a pure decision stage. Parameter `OUT_REG` selects between two variants:

- **Registered (default):** the outputs are flopped. They appear one clock after the inputs, and a synchronous reset clears them.
- **Combinational:** the outputs follow the inputs in the same cycle.

There is no state machine. The datapath has three stages, in this order:

1. Fold the requests by level.
2. Mask them against the current level.
3. Pick the highest remaining level with a priority encoder.

Top module: `soft_irq_resolver`

## Requirements
- R1: With cur_lvl below 14 and pend_vec bit 16 set, a grant at level 14 is made, unless a higher level qualifies.
- R2: With cur_lvl below 14 and pend_vec bit 0 set, a grant at level 14 is made, unless a higher level qualifies.
- R3: Each pend_vec bit k, for k from 1 to 15, requests level k. The granted level is the highest requested level that is strictly greater than cur_lvl.
- R4: Bit 0 never acts as a level-0 or ordinary request. With only bit 0 set and cur_lvl of 14 or more, grant_valid is 0.
- R5: When no request qualifies, grant_valid is 0 and grant_lvl is 0.
- R6: When bit 15 and a timer flag (bit 0 or bit 16) are both eligible, the grant is level 15.
- R7: cur_lvl = 15 masks every request, the timer flags included.
- R8: A request whose level equals cur_lvl is not granted.
- R9: With OUT_REG = 1, the outputs reflect the inputs sampled at the previous rising clock edge. While rst is high at a rising edge, grant_valid and grant_lvl are cleared to 0.
- R10: With OUT_REG = 0, the outputs follow the inputs in the same cycle and use the same mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high; clears the registered outputs |
| pend_vec | input | 17 | Pending requests: bits 0 and 16 are level-14 timer flags, bits 1 to 15 request their own index |
| cur_lvl | input | 4 | Current processor interrupt level |
| grant_valid | output | 1 | A request qualifies |
| grant_lvl | output | 4 | Level to service; 0 when grant_valid is 0 |

## Verification
An error in the fold stage or the mask stage shows up directly at the grant outputs, one clock later in the registered variant and at once in the combinational one. Typical symptoms are a timer flag that is lost or sent to the wrong level, or a request at the current level that leaks through. Both variants are compared on every cycle against a behavioural model. The stimulus includes the contested cases: bit 15 against the timer flags, requests exactly at cur_lvl, and cur_lvl at 14 and 15. These cases expose an encoder with the wrong priority order within the first few directed steps.

// File: rtl/sir_pkg.sv
package sir_pkg;
    localparam int LVL_W     = 4;
    localparam int NUM_LVL   = 1 << LVL_W;
    localparam int VEC_W     = NUM_LVL + 1;
    localparam int ALIAS_LVL = 14;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/sir_req_fold.sv
module sir_req_fold
    import sir_pkg::*;
#(
    parameter int NLVL  = NUM_LVL,
    parameter int VW    = NLVL + 1,
    parameter int ALIAS = ALIAS_LVL
) (
    input  logic [VW-1:0]   vec,
    output logic [NLVL-1:0] req_by_lvl
);
    // Level 0 never requests; the timer flags at the ends of the vector fold into ALIAS.
    assign req_by_lvl[0] = 1'b0;
    generate
        for (genvar k = 1; k < NLVL; k++) begin : g_lvl
            if (k == ALIAS) begin : g_alias
                assign req_by_lvl[k] = vec[k] | vec[0] | vec[VW-1];
            end else begin : g_plain
                assign req_by_lvl[k] = vec[k];
            end
        end
    endgenerate

    always_comb begin
        if (!$isunknown(vec) && (vec[0] || vec[VW-1]))
            AST_ALIAS_FOLDED: assert (req_by_lvl[ALIAS]);              // R1
    end
endmodule

// File: rtl/sir_lvl_mask.sv
module sir_lvl_mask
    import sir_pkg::*;
#(
    parameter int NLVL = NUM_LVL,
    parameter int LW   = $clog2(NLVL)
) (
    input  logic [NLVL-1:0] req,
    input  logic [LW-1:0]   cur,
    output logic [NLVL-1:0] elig
);
    generate
        for (genvar k = 0; k < NLVL; k++) begin : g_m
            assign elig[k] = req[k] && (LW'(k) > cur);
        end
    endgenerate

    always_comb begin
        if (!$isunknown({req, cur}))
            AST_NO_EQ_LEAK: assert (!elig[cur]);                       // R8
    end
endmodule

// File: rtl/sir_prio_enc.sv
module sir_prio_enc
    import sir_pkg::*;
#(
    parameter int NLVL = NUM_LVL,
    parameter int LW   = $clog2(NLVL)
) (
    input  logic [NLVL-1:0] elig,
    output logic            any,
    output logic [LW-1:0]   top
);
    always_comb begin
        any = 1'b0;
        top = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (elig[i]) begin
                any = 1'b1;
                top = LW'(i);
            end
        end
    end

    always_comb begin
        if (!$isunknown(elig)) begin
            if (!any) AST_IDLE_ZERO: assert (top == '0);               // R5
            if (any)  AST_WINNER_SET: assert (elig[top]);              // R3
            if (any)  AST_NONE_ABOVE: assert ((elig >> top) == NLVL'(1)); // R6
        end
    end
endmodule

// File: rtl/soft_irq_resolver.sv
module soft_irq_resolver
    import sir_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VEC_W-1:0] pend_vec,
    input  logic [LVL_W-1:0] cur_lvl,
    output logic             grant_valid,
    output logic [LVL_W-1:0] grant_lvl
);
    logic [NUM_LVL-1:0] req_w;
    logic [NUM_LVL-1:0] elig_w;
    logic               nxt_valid;
    lvl_t               nxt_lvl;

    sir_req_fold #(.NLVL(NUM_LVL), .VW(VEC_W), .ALIAS(ALIAS_LVL)) u_fold (
        .vec        (pend_vec),
        .req_by_lvl (req_w)
    );

    sir_lvl_mask #(.NLVL(NUM_LVL), .LW(LVL_W)) u_mask (
        .req  (req_w),
        .cur  (cur_lvl),
        .elig (elig_w)
    );

    sir_prio_enc #(.NLVL(NUM_LVL), .LW(LVL_W)) u_enc (
        .elig (elig_w),
        .any  (nxt_valid),
        .top  (nxt_lvl)
    );

    always_comb begin
        if (!$isunknown({pend_vec, cur_lvl})) begin
            if (nxt_valid) AST_ABOVE_CUR: assert (nxt_lvl > cur_lvl);                       // R3
            if (cur_lvl == LVL_W'(NUM_LVL-1)) AST_TOP_MASKS: assert (!nxt_valid);            // R7
            if (pend_vec[NUM_LVL-1] && cur_lvl != LVL_W'(NUM_LVL-1))
                AST_B15_WINS: assert (nxt_lvl == LVL_W'(NUM_LVL-1));                         // R6
        end
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    grant_valid <= 1'b0;
                    grant_lvl   <= '0;
                end else begin
                    grant_valid <= nxt_valid;
                    grant_lvl   <= nxt_lvl;
                end
            end

            AST_REG_NONZERO: assert property (@(posedge clk) disable iff (rst)
                grant_valid |-> (grant_lvl != '0));                                         // R9
        end else begin : g_comb
            assign grant_valid = nxt_valid;
            assign grant_lvl   = nxt_lvl;
        end
    endgenerate
endmodule

// File: tb/tb_soft_irq_resolver.sv
module tb_soft_irq_resolver;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [16:0] pend_vec = '0;
    logic [3:0]  cur_lvl = '0;
    logic        r_valid, c_valid;
    logic [3:0]  r_lvl, c_lvl;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    soft_irq_resolver #(.OUT_REG(1'b1)) dut (
        .clk(clk), .rst(rst), .pend_vec(pend_vec), .cur_lvl(cur_lvl),
        .grant_valid(r_valid), .grant_lvl(r_lvl));

    soft_irq_resolver #(.OUT_REG(1'b0)) dut_comb (
        .clk(clk), .rst(rst), .pend_vec(pend_vec), .cur_lvl(cur_lvl),
        .grant_valid(c_valid), .grant_lvl(c_lvl));

    function automatic int model(input logic [16:0] v, input int cur);
        int best = 0;
        if (cur < 14 && (v[16] || v[0])) best = 14;
        for (int b = 15; b >= 1; b--)
            if (v[b] && b > cur && b > best) best = b;
        return best;
    endfunction

    task automatic check(input string tag, input logic av, input logic [3:0] al,
                         input int el);
        n_cmp++;
        if (av !== (el != 0) || al !== 4'(el)) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b lvl=%0d, expected valid=%0b lvl=%0d",
                     tag, av, al, (el != 0), el);
        end
    endtask

    // Drive at a falling edge; the next rising edge registers; compare at the following falling edge.
    task automatic step(input logic [16:0] v, input logic [3:0] c, input string tag);
        int e;
        pend_vec = v;
        cur_lvl  = c;
        e = model(v, int'(c));
        @(negedge clk);
        check({tag, " reg"}, r_valid, r_lvl, e);
        check({tag, " R10 comb"}, c_valid, c_lvl, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset", r_valid, r_lvl, 0);
        rst = 1'b0;
        step(17'h10000, 4'd3,  "R1");
        step(17'h10000, 4'd13, "R1");
        step(17'h00001, 4'd0,  "R2");
        step(17'h00001, 4'd13, "R2");
        step(17'h00001, 4'd14, "R4");
        step(17'h00001, 4'd15, "R4");
        step(17'h00000, 4'd0,  "R5");
        step(17'h00002, 4'd1,  "R8");
        step(17'h00020, 4'd5,  "R8");
        step(17'h04000, 4'd14, "R8");
        step(17'h00124, 4'd2,  "R3");
        step(17'h00124, 4'd5,  "R3");
        step(17'h00124, 4'd8,  "R5");
        step(17'h18001, 4'd0,  "R6");
        step(17'h08001, 4'd13, "R6");
        step(17'h18000, 4'd14, "R6");
        step(17'h1FFFF, 4'd15, "R7");
        step(17'h10001, 4'd15, "R7");
        step(17'h02000, 4'd0,  "R3");
        // Reset with a live request must clear the registered grant.
        pend_vec = 17'h08000; cur_lvl = 4'd0; rst = 1'b1;
        @(negedge clk);
        check("R9 reset clear", r_valid, r_lvl, 0);
        rst = 1'b0;
        step(17'h08000, 4'd0, "R9");
        for (int i = 0; i < 400; i++)
            step(17'($urandom), 4'($urandom), "R3 random");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule